// File: doc/BRIEF.md
# Cascadable Serial Configuration Streamer

This block feeds the contents of a word-organised memory, one bit per serial clock, into a programmable device that is loading its configuration. The loading device supplies the serial clock and samples the data on its rising edge. The streamer updates its data on the falling edge, so each bit is stable around the sampling edge. The memory itself sits outside the block and is reached through a synchronous word read port. The streamer requests the following word while the current one is still being shifted, so the bit stream has no gaps at word boundaries.

Several streamers can share one data line. Each one has an active-low enable input and an active-low chain output. When a streamer has sent the final bit of its memory, it floats its data output and drives the chain output low. That output enables the next streamer in the chain. A chain reset input, whose active level is chosen by a configuration bit, sends the counters back to the first bit. A ready output stays low during a power-on initialisation interval. While the mode-select input chooses programming mode, the streamer stays quiet and keeps its position.

Top module: `serial_cfg_streamer`

## Requirements
- R1: After `rst_n` is released, `ready` stays low for exactly INIT_CYCLES falling clock edges and then stays high. While `ready` is low, `data_oe` is 0 and `chain_out_n` is 1.
- R2: The chain reset is active when `chain_rst` equals `rst_pol_high`. That gives active-low with `rst_pol_high`=0 and active-high with `rst_pol_high`=1. While it is active, and whatever `en_n` does, `data_oe` is 0 and `chain_out_n` is 1. Each falling edge during an active reset moves the position back to bit 0 of word 0 and clears the finished state.
- R3: With the reset inactive and `en_n` high, `data_oe` is 0 and the position is frozen. Streaming later continues from the same bit.
- R4: If `en_n` is low when the reset is released, then from that moment `data_oe` is 1 and `data_out` already shows bit 31 of word 0, before any clock edge.
- R5: While streaming, each falling edge moves to the next bit. Bits of a 32-bit word go out from bit 31 down to bit 0. Words go out in ascending address order, and the last bit of one word is followed directly by the first bit of the next.
- R6: Bit 0 of word DEPTH_WORDS-1 is presented for one clock period. From the next falling edge on, `data_oe` is 0 and `chain_out_n` is 0, whatever `en_n` does, until an active chain reset.
- R7: While `prog_n` is 0, `data_oe` is 0 and `chain_out_n` is 1. In that mode the chain reset and `en_n` have no effect, and the position is kept.
- R8: `mem_addr` is 0 while `ready` is low or an active chain reset is applied. Otherwise it is the current word index plus one, modulo 2^AW. Read data is expected one falling edge after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading device; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| prog_n | input | 1 | Mode select; 0 selects programming mode, in which the streamer is idle |
| chain_rst | input | 1 | Chain reset pin, active level set by `rst_pol_high` |
| rst_pol_high | input | 1 | Reset polarity configuration; 0 selects active-low (default) |
| en_n | input | 1 | Active-low enable input from the previous stage of the chain |
| mem_addr | output | AW | Word address to the synchronous read port |
| mem_rdata | input | WORD_W | Word read data, valid one falling edge after the address |
| data_out | output | 1 | Serial data bit |
| data_oe | output | 1 | Output enable for the data pin; 0 means high impedance |
| chain_out_n | output | 1 | Active-low enable to the next stage, low once the memory is exhausted |
| ready | output | 1 | High once power-on initialisation has finished |

## Verification
The assertions rely on three conditions. An active chain reset outside programming mode lasts at least two clock periods, so the first word can be reloaded. The read port returns static contents with one falling edge of latency. The inputs change only shortly after a falling edge. The bench builds its random traffic from segments that follow these rules. Reset segments hold the reset for two to four cycles with programming mode off. A polarity change always comes with the inactive level for the new setting. All pins are driven one time step after the falling edge, and the memory model is a pure function of the address behind a one-edge register.

// File: rtl/scs_pkg.sv
// Shared types for the serial configuration streamer.
// Assumes one clock domain, the serial clock, with updates on its falling edge.
package scs_pkg;

    // Operating mode, listed in priority order (the first match wins).
    typedef enum logic [2:0] {
        M_INIT,
        M_PROG,
        M_RESET,
        M_DONE,
        M_STANDBY,
        M_STREAM
    } scs_mode_e;

    // Chain reset is active when the pin equals the configured active level.
    function automatic logic chain_rst_active(input logic pin, input logic pol_high);
        return pin == pol_high;
    endfunction

endpackage

// File: rtl/scs_por.sv
// Power-on sequencer: holds ready low for INIT_CYCLES falling edges after rst_n.
// Assumes INIT_CYCLES >= 2 so the first word can be loaded while ready is low.
module scs_por #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count the initialisation interval, then raise ready for good.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt == CW'(INIT_CYCLES - 1)) ready <= 1'b1;
            else                             cnt   <= cnt + 1'b1;
        end
    end

    // R1: once raised, ready never drops without a power-on reset.
    assert_ready_sticky_R1: assert property (@(negedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/scs_mode.sv
// Mode decoder and pin driver: picks the operating mode from the inputs and the
// finished flag, then drives data, output enable and the chain output.
// Assumes inputs are stable around the falling edge.
module scs_mode
    import scs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ready,
    input  logic      prog_n,
    input  logic      chain_rst,
    input  logic      rst_pol_high,
    input  logic      en_n,
    input  logic      done,
    input  logic      shift_msb,
    output scs_mode_e mode,
    output logic      data_out,
    output logic      data_oe,
    output logic      chain_out_n
);
    // Priority decode of the operating mode.
    always_comb begin
        if (!ready)                                      mode = M_INIT;
        else if (!prog_n)                                mode = M_PROG;
        else if (chain_rst_active(chain_rst, rst_pol_high)) mode = M_RESET;
        else if (done)                                   mode = M_DONE;
        else if (en_n)                                   mode = M_STANDBY;
        else                                             mode = M_STREAM;
    end

    // Pin drive: data only while streaming, chain handoff only when finished.
    always_comb begin
        data_oe     = (mode == M_STREAM);
        data_out    = data_oe ? shift_msb : 1'b0;
        chain_out_n = (mode != M_DONE);
    end

    // R1: the pins stay quiet until initialisation ends.
    assert_init_quiet_R1: assert property (@(negedge clk) disable iff (!rst_n)
        !ready |-> (!data_oe && chain_out_n));

    // R7: programming mode never drives the data pin or the chain output.
    assert_prog_quiet_R7: assert property (@(negedge clk) disable iff (!rst_n)
        !prog_n |-> (!data_oe && chain_out_n));

endmodule

// File: rtl/scs_cursor.sv
// Position and shift datapath: word index, bit index, one-word shift register
// and the finished flag. Requests word+1 while the current word is shifting.
// Assumes the read port returns data one falling edge after the address.
module scs_cursor
    import scs_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int DEPTH_WORDS = 131072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scs_mode_e         mode,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [$clog2(DEPTH_WORDS)-1:0] mem_addr,
    output logic              shift_msb,
    output logic              done
);
    localparam int AW = $clog2(DEPTH_WORDS);
    localparam int BW = $clog2(WORD_W);
    localparam logic [AW-1:0] LAST_WORD = AW'(DEPTH_WORDS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);

    logic [AW-1:0]     word_idx;
    logic [BW-1:0]     bit_idx;
    logic [WORD_W-1:0] shreg;

    // Advance, reload or hold the read position according to the mode.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            done     <= 1'b0;
        end else begin
            case (mode)
                M_INIT, M_RESET: begin
                    word_idx <= '0;
                    bit_idx  <= '0;
                    done     <= 1'b0;
                    shreg    <= mem_rdata;
                end
                M_STREAM: begin
                    if (bit_idx == LAST_BIT) begin
                        if (word_idx == LAST_WORD) begin
                            done <= 1'b1;
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            bit_idx  <= '0;
                            shreg    <= mem_rdata;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[WORD_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    // Address the first word during reload, otherwise prefetch the next word.
    always_comb begin
        if (mode == M_INIT || mode == M_RESET) mem_addr = '0;
        else                                   mem_addr = word_idx + 1'b1;
        shift_msb = shreg[WORD_W-1];
    end

    // R2: an active reset returns to the first bit and clears the finished state.
    assert_reset_home_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == M_RESET) |=> (word_idx == '0 && bit_idx == '0 && !done));

    // R3: standby freezes the position and the shift register.
    assert_standby_hold_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == M_STANDBY) |=> ($stable(word_idx) && $stable(bit_idx) && $stable(shreg)));

    // R5: inside a word, each streaming edge moves exactly one bit on.
    assert_bit_step_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == M_STREAM && bit_idx != LAST_BIT) |=> (bit_idx == $past(bit_idx) + 1'b1));

    // R6: the finished state persists until a reset clears it.
    assert_done_sticky_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (done && mode != M_RESET && mode != M_INIT) |=> done);

    // R7: programming mode keeps the position untouched.
    assert_prog_hold_R7: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == M_PROG) |=> ($stable(word_idx) && $stable(bit_idx) && $stable(done)));

endmodule

// File: rtl/serial_cfg_streamer.sv
// Top level of the cascadable serial configuration streamer: power-on
// sequencer, mode decoder and position datapath, all on the falling edge.
// Assumes an external synchronous word memory with one edge of read latency.
module serial_cfg_streamer
    import scs_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int DEPTH_WORDS = 131072,
    parameter int INIT_CYCLES = 16,
    localparam int AW         = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic              chain_rst,
    input  logic              rst_pol_high,
    input  logic              en_n,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              data_out,
    output logic              data_oe,
    output logic              chain_out_n,
    output logic              ready
);
    scs_mode_e mode;
    logic      done;
    logic      shift_msb;

    scs_por #(.INIT_CYCLES(INIT_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    scs_mode u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready        (ready),
        .prog_n       (prog_n),
        .chain_rst    (chain_rst),
        .rst_pol_high (rst_pol_high),
        .en_n         (en_n),
        .done         (done),
        .shift_msb    (shift_msb),
        .mode         (mode),
        .data_out     (data_out),
        .data_oe      (data_oe),
        .chain_out_n  (chain_out_n)
    );

    scs_cursor #(.WORD_W(WORD_W), .DEPTH_WORDS(DEPTH_WORDS)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .shift_msb (shift_msb),
        .done      (done)
    );

endmodule

// File: tb/sim_serial_cfg_streamer.sv
// Self-checking bench: directed corner cases followed by seeded random segments,
// compared against a bench reference model of the requirements.
module sim_serial_cfg_streamer;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 8;
    localparam int INIT   = 6;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n, prog_n, chain_rst, rst_pol_high, en_n;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic data_out, data_oe, chain_out_n, ready;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // model state
    int  m_por = 0;
    int  m_w = 0;
    int  m_b = 0;
    bit  m_done = 0;

    always #5 clk = ~clk;

    serial_cfg_streamer #(.WORD_W(WORD_W), .DEPTH_WORDS(DEPTH), .INIT_CYCLES(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .chain_rst(chain_rst),
        .rst_pol_high(rst_pol_high), .en_n(en_n), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .data_out(data_out), .data_oe(data_oe),
        .chain_out_n(chain_out_n), .ready(ready)
    );

    function automatic logic [31:0] word_of(int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'h5A5A_0F0F ^ (32'(i) << 13);
    endfunction

    // synchronous memory model, one falling edge of latency
    always @(negedge clk) mem_rdata <= word_of(int'(mem_addr));

    // modes: 0 init, 1 prog, 2 reset, 3 done, 4 standby, 5 stream
    function automatic int exp_mode();
        if (m_por < INIT)                 return 0;
        if (!prog_n)                      return 1;
        if (chain_rst == rst_pol_high)    return 2;
        if (m_done)                       return 3;
        if (en_n)                         return 4;
        return 5;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int md = exp_mode();
        string tg;
        logic [AW-1:0] ea;
        case (md)
            0: tg = "R1";
            1: tg = "R7";
            2: tg = "R2";
            3: tg = "R6";
            4: tg = "R3";
            default: tg = (m_w == 0 && m_b == 0) ? "R4" : "R5";
        endcase
        chk("R1", ready, (m_por >= INIT), "ready");
        chk(tg, data_oe, (md == 5), "data_oe");
        chk(tg, chain_out_n, (md != 3), "chain_out_n");
        if (md == 5) begin
            logic [31:0] wv = word_of(m_w);
            chk(tg, data_out, wv[31 - m_b], "data_out");
        end
        ea = (md == 0 || md == 2) ? '0 : AW'(m_w + 1);
        chk("R8", mem_addr, ea, "mem_addr");
    endtask

    task automatic model_update();
        int md = exp_mode();
        if (!rst_n) begin
            m_por = 0; m_w = 0; m_b = 0; m_done = 0;
            return;
        end
        case (md)
            0, 2: begin m_w = 0; m_b = 0; m_done = 0; end
            5: begin
                if (m_b == 31) begin
                    if (m_w == DEPTH - 1) m_done = 1;
                    else begin m_w++; m_b = 0; end
                end else m_b++;
            end
            default: ;
        endcase
        if (m_por < INIT) m_por++;
    endtask

    // inputs are driven just after a falling edge; sample after the rising edge
    task automatic run_cycle();
        @(posedge clk); #1;
        compare();
        model_update();
        @(negedge clk); #1;
    endtask

    task automatic set_in(bit prog_on, bit rst_on, bit en_on);
        prog_n    = !prog_on;
        chain_rst = rst_on ? rst_pol_high : !rst_pol_high;
        en_n      = !en_on;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) run_cycle();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rst_pol_high = 1'b0;
        set_in(0, 0, 1);
        @(negedge clk); #1;
        // reset state, R1
        run(3);
        rst_n = 1'b1;
        // R1 init interval, then immediate streaming of word 0 (R4)
        run(INIT + 40);
        // R2 active-low reset with enable low, then R4 first bit at release
        set_in(0, 1, 1); run(3);
        set_in(0, 0, 1); run(70);
        // R3 standby and resume
        set_in(0, 0, 0); run(5);
        set_in(0, 0, 1); run(10);
        // R7 programming mode with reset and enable wiggling
        for (int i = 0; i < 6; i++) begin
            set_in(1, i[0], i[1]); run(1);
        end
        set_in(0, 0, 1); run(DEPTH * 32);
        // R6 finished state stays through enable changes
        set_in(0, 0, 0); run(3);
        set_in(0, 0, 1); run(3);
        // R2 active-high polarity clears the finished state
        rst_pol_high = 1'b1; set_in(0, 0, 1); run(2);
        set_in(0, 1, 0); run(2);
        set_in(0, 0, 1); run(40);
        // random segments
        for (int s = 0; s < 900; s++) begin
            int kind = int'($urandom % 10);
            int len;
            case (kind)
                0, 1, 2, 3, 4: begin len = 1 + int'($urandom % 60); set_in(0, 0, 1); run(len); end
                5: begin len = 1 + int'($urandom % 8); set_in(0, 0, 0); run(len); end
                6: begin len = 2 + int'($urandom % 3); set_in(0, 1, $urandom % 2); run(len); end
                7: begin
                    len = 1 + int'($urandom % 8);
                    for (int k = 0; k < len; k++) begin
                        set_in(1, $urandom % 2, $urandom % 2); run(1);
                    end
                end
                8: begin rst_pol_high = ~rst_pol_high; set_in(0, 0, 1); run(1); end
                default: begin set_in(0, 0, 1); run(300); end
            endcase
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule